// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block holds the eight 32-bit general-purpose program registers of a small single-cycle processor. Each register is named by a 4-bit identifier. Two read ports, A and B, return register contents combinationally from the identifiers presented in the same cycle. Two write ports commit on the rising clock edge. Port E carries the ALU result. Port M carries the word loaded from data memory. Both write ports may update registers in the same cycle.

Identifiers 0 to 7 select registers 0 to 7. Identifier 15 is the "no register" code. Identifiers 8 to 14 are illegal and act exactly like 15. A read of any such identifier yields zero, and a write to one leaves every register as it was. A synchronous, active-high reset clears all registers. The surrounding processor decodes instructions and picks the identifiers. This block does no forwarding.

Top module: `dual_wr_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, all eight registers become zero, so every read of identifier 0 to 7 after that edge returns 0 until the next write.
- R2: Port A returns, in the same cycle and without waiting for a clock, the current content of the register whose identifier (0 to 7) is on `rdIdA`.
- R3: Port B does the same from `rdIdB`, independently of port A, including when both ports name different registers.
- R4: When `wrIdE` is 0 to 7 at a rising edge (reset low), `wrDataE` is stored in that register and is visible on the read ports from then on.
- R5: When `wrIdM` is 0 to 7 at a rising edge (reset low), `wrDataM` is stored in that register and is visible from then on.
- R6: When E and M name two different legal registers at the same edge, both registers are written.
- R7: When E and M name the same legal register at the same edge, that register takes `wrDataM` and `wrDataE` is dropped.
- R8: A read of identifier 15 (0xF) on either port returns 0.
- R9: A write on either port with an identifier of 8 to 15 changes no register.
- R10: A read of identifiers 8 to 14 on either port returns 0.
- R11: A read of a register during the cycle in which it is being written returns the value held before the edge. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| rdIdA | input | 4 | Register identifier for read port A |
| rdIdB | input | 4 | Register identifier for read port B |
| rdDataA | output | 32 | Combinational read data, port A |
| rdDataB | output | 32 | Combinational read data, port B |
| wrIdE | input | 4 | Destination identifier for the ALU result |
| wrDataE | input | 32 | ALU result to be written |
| wrIdM | input | 4 | Destination identifier for the memory load |
| wrDataM | input | 32 | Loaded word to be written |

## Verification
Read results are due in the same cycle as their identifiers. The bench therefore changes identifiers on the falling edge and samples the read data one time unit later, with no clock edge in between. A write, or a clear, is due after exactly one rising edge. The bench samples it on the following falling edge. For the same-cycle read of a register that is being written, the bench samples once before the edge, where it expects the old value, and once after the edge, where it expects the new value. The bound assertions use the same one-edge latency. They relate each write on E or M, and each idle cycle, to the read data one edge later.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DATA_W   = 32;
  localparam int RF_NUM_REGS = 8;
  localparam int RF_ID_W     = 4;
  localparam int RF_IDX_W    = $clog2(RF_NUM_REGS);

  typedef logic [RF_ID_W-1:0]   regId_t;
  typedef logic [RF_DATA_W-1:0] word_t;
  typedef logic [RF_IDX_W-1:0]  regIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                   clr;
    logic [RF_NUM_REGS-1:0] selE;
    logic [RF_NUM_REGS-1:0] selM;
    logic                   rdOkA;
    logic                   rdOkB;
  } rfStrobe_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
(
  input  logic      rst,
  input  regId_t    rdIdA,
  input  regId_t    rdIdB,
  input  regId_t    wrIdE,
  input  regId_t    wrIdM,
  output rfStrobe_t strobe
);
  localparam regId_t LIMIT = regId_t'(RF_NUM_REGS);

  logic [RF_NUM_REGS-1:0] hitE;
  logic [RF_NUM_REGS-1:0] hitM;

  genvar i;
  generate
    for (i = 0; i < RF_NUM_REGS; i++) begin : g_dec
      assign hitE[i] = (wrIdE == regId_t'(i));
      assign hitM[i] = (wrIdM == regId_t'(i));
    end
  endgenerate

  always_comb begin
    strobe.clr   = rst;
    // memory port takes priority on a shared destination
    strobe.selM  = hitM;
    strobe.selE  = hitE & ~hitM;
    strobe.rdOkA = (rdIdA < LIMIT);
    strobe.rdOkB = (rdIdB < LIMIT);
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
(
  input  logic      clk,
  input  rfStrobe_t strobe,
  input  regIdx_t   rdIdxA,
  input  regIdx_t   rdIdxB,
  input  word_t     wrDataE,
  input  word_t     wrDataM,
  output word_t     rdDataA,
  output word_t     rdDataB
);
  word_t regs [RF_NUM_REGS];

  genvar i;
  generate
    for (i = 0; i < RF_NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (strobe.clr)         regs[i] <= '0;
        else if (strobe.selM[i]) regs[i] <= wrDataM;
        else if (strobe.selE[i]) regs[i] <= wrDataE;
      end
    end
  endgenerate

  always_comb begin
    rdDataA = strobe.rdOkA ? regs[rdIdxA] : '0;
    rdDataB = strobe.rdOkB ? regs[rdIdxB] : '0;
  end
endmodule

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile
  import rf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RF_ID_W-1:0]   rdIdA,
  input  logic [RF_ID_W-1:0]   rdIdB,
  output logic [RF_DATA_W-1:0] rdDataA,
  output logic [RF_DATA_W-1:0] rdDataB,
  input  logic [RF_ID_W-1:0]   wrIdE,
  input  logic [RF_DATA_W-1:0] wrDataE,
  input  logic [RF_ID_W-1:0]   wrIdM,
  input  logic [RF_DATA_W-1:0] wrDataM
);
  rfStrobe_t strobe;

  rf_ctrl u_ctrl (
    .rst    (rst),
    .rdIdA  (rdIdA),
    .rdIdB  (rdIdB),
    .wrIdE  (wrIdE),
    .wrIdM  (wrIdM),
    .strobe (strobe)
  );

  rf_datapath u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .rdIdxA  (rdIdA[RF_IDX_W-1:0]),
    .rdIdxB  (rdIdB[RF_IDX_W-1:0]),
    .wrDataE (wrDataE),
    .wrDataM (wrDataM),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [RF_ID_W-1:0]   rdIdA,
  input logic [RF_ID_W-1:0]   rdIdB,
  input logic [RF_DATA_W-1:0] rdDataA,
  input logic [RF_DATA_W-1:0] rdDataB,
  input logic [RF_ID_W-1:0]   wrIdE,
  input logic [RF_DATA_W-1:0] wrDataE,
  input logic [RF_ID_W-1:0]   wrIdM,
  input logic [RF_DATA_W-1:0] wrDataM
);
  localparam logic [RF_ID_W-1:0] LIMIT = RF_ID_W'(RF_NUM_REGS);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (rdDataA == '0 && rdDataB == '0));

  // R8 R10
  null_read_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rdIdA >= LIMIT) |-> (rdDataA == '0));

  // R8 R10
  null_read_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rdIdB >= LIMIT) |-> (rdDataB == '0));

  // R4 R6
  e_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrIdE < LIMIT && wrIdE != wrIdM) |=>
      (rdIdA != $past(wrIdE)) || (rdDataA == $past(wrDataE)));

  // R5 R7
  m_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrIdM < LIMIT) |=>
      (rdIdB != $past(wrIdM)) || (rdDataB == $past(wrDataM)));

  // R9
  null_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrIdE >= LIMIT && wrIdM >= LIMIT) |=>
      (rdIdA != $past(rdIdA)) || $stable(rdDataA));
endmodule

bind dual_wr_regfile rf_checker u_chk (.*);

// File: tb/sim_dual_wr_regfile.sv
module sim_dual_wr_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] NUL = 4'hF;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rdIdA, rdIdB, wrIdE, wrIdM;
  logic [31:0] rdDataA, rdDataB, wrDataE, wrDataM;
  logic [31:0] model [8];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wr_regfile u0 (
    .clk(clk), .rst(rst), .rdIdA(rdIdA), .rdIdB(rdIdB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrIdE(wrIdE), .wrDataE(wrDataE), .wrIdM(wrIdM), .wrDataM(wrDataM)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setRead(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    rdIdA = a; rdIdB = b;
    #1;
  endtask

  // one write cycle, then idle; model updated per R4/R5/R7
  task automatic doWrite(input logic [3:0] ie, input logic [31:0] de,
                         input logic [3:0] im, input logic [31:0] dm);
    @(negedge clk);
    wrIdE = ie; wrDataE = de; wrIdM = im; wrDataM = dm;
    @(posedge clk);
    if (ie < 8) model[ie[2:0]] = de;
    if (im < 8) model[im[2:0]] = dm;
    @(negedge clk);
    wrIdE = NUL; wrIdM = NUL;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) begin
      setRead(4'(i), 4'(7 - i));
      check("R1 portA", rdDataA, 32'h0);
      check("R1 portB", rdDataB, 32'h0);
    end
  endtask

  task automatic t_write_e;
    for (int i = 0; i < 8; i++) doWrite(4'(i), 32'hA000_0000 + 32'(i * 17), NUL, 32'hDEAD);
    for (int i = 0; i < 8; i++) begin
      setRead(4'(i), NUL);
      check("R4/R2 E write via A", rdDataA, model[i]);
    end
  endtask

  task automatic t_write_m;
    for (int i = 0; i < 8; i++) doWrite(NUL, 32'hBEEF, 4'(i), 32'h5000_0000 ^ 32'(i * 331));
    for (int i = 0; i < 8; i++) begin
      setRead(4'(7 - i), 4'(i));
      check("R5 M write via B", rdDataB, 32'h5000_0000 ^ 32'(i * 331));
      check("R3 independent A", rdDataA, model[7 - i]);
    end
  endtask

  task automatic t_dual;
    doWrite(4'd2, 32'h1111_2222, 4'd5, 32'h3333_4444);
    setRead(4'd2, 4'd5);
    check("R6 E target", rdDataA, 32'h1111_2222);
    check("R6 M target", rdDataB, 32'h3333_4444);
  endtask

  task automatic t_collide;
    doWrite(4'd3, 32'hEEEE_EEEE, 4'd3, 32'h7777_7777);
    setRead(4'd3, 4'd3);
    check("R7 M wins A", rdDataA, 32'h7777_7777);
    check("R7 M wins B", rdDataB, 32'h7777_7777);
  endtask

  task automatic t_null_read;
    setRead(NUL, NUL);
    check("R8 A", rdDataA, 32'h0);
    check("R8 B", rdDataB, 32'h0);
    for (int i = 8; i < 15; i++) begin
      setRead(4'(i), 4'(i));
      check("R10 A", rdDataA, 32'h0);
      check("R10 B", rdDataB, 32'h0);
    end
  endtask

  task automatic t_null_write;
    for (int i = 8; i < 16; i++) doWrite(4'(i), 32'hFACE_0000 + 32'(i), 4'(23 - i), 32'hC0DE_0000 + 32'(i));
    for (int i = 0; i < 8; i++) begin
      setRead(4'(i), 4'(i));
      check("R9 unchanged A", rdDataA, model[i]);
      check("R9 unchanged B", rdDataB, model[i]);
    end
  endtask

  task automatic t_old_value;
    logic [31:0] oldV;
    oldV = model[1];
    @(negedge clk);
    rdIdA = 4'd1; rdIdB = 4'd6;
    wrIdE = 4'd1; wrDataE = 32'h0BAD_F00D;
    wrIdM = 4'd6; wrDataM = 32'h600D_CAFE;
    #1;
    check("R11 old A before edge", rdDataA, oldV);
    check("R11 old B before edge", rdDataB, model[6]);
    @(posedge clk);
    model[1] = 32'h0BAD_F00D; model[6] = 32'h600D_CAFE;
    @(negedge clk);
    wrIdE = NUL; wrIdM = NUL;
    #1;
    check("R11/R4 new A after edge", rdDataA, 32'h0BAD_F00D);
    check("R11/R5 new B after edge", rdDataB, 32'h600D_CAFE);
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    setRead(4'd1, 4'd6);
    check("R1 clear after data A", rdDataA, 32'h0);
    check("R1 clear after data B", rdDataB, 32'h0);
  endtask

  initial begin
    rst = 1'b1;
    rdIdA = NUL; rdIdB = NUL;
    wrIdE = NUL; wrIdM = NUL;
    wrDataE = '0; wrDataM = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_e();
    t_write_m();
    t_dual();
    t_collide();
    t_null_read();
    t_null_write();
    t_old_value();
    t_reset_again();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule